// File: doc/BRIEF.md
# SPI Target Controller with Split Shared-Memory FIFOs

This block is a SPI target (slave) that exchanges bytes between a SPI bus and a 2 KB buffer that is also visible to a CPU. One half of the buffer (1 KB) is a receive ring and the other half (1 KB) is a transmit ring. Each ring has two pointers, and each pointer has exactly one owner. On the receive ring, the controller moves the head pointer as bytes arrive and the CPU moves the tail pointer. On the transmit ring, the CPU moves the head pointer and the controller moves the tail pointer as bytes go out.

Each pointer is 11 bits wide. The low 10 bits give a byte position inside the 1 KB ring. Bit 10 toggles every time the pointer wraps, so a full ring and an empty ring have different pointer values. The CPU may write ring memory only as aligned 32-bit words. It may read ring memory at byte, halfword or word size. The SPI pins are sampled in the system clock domain through synchronisers, so SCLK must be several times slower than the system clock. The `rx_irq` output signals when enough received data is waiting.

Top module: `spi_target_fifo`

## Requirements
- R1: After reset, all four pointers read 0 and the status register reads 0x05 (both rings empty, both sticky flags clear). `rx_irq` is low because the threshold resets to 1.
- R2: The controller samples MOSI on the rising edge of SCLK (SPI mode 0), MSB first, while CS_N is low. The k-th received byte is stored in byte lane k%4 of word k/4 of the receive ring (CPU byte address k, bytes 0x000–0x3FF). The receive head pointer (register 0x800, read-only) then advances by one.
- R3: The CPU writes transmit data as words at 0x400–0x7FF (byte k in lane k%4) and publishes it by writing the transmit head pointer (register 0x808). The controller shifts these bytes out on MISO in order, MSB first. Each bit is valid before the rising edge that samples it. The transmit tail pointer (register 0x80C, read-only) advances once for each byte whose first bit has been clocked.
- R4: When the transmit ring is empty at the moment a byte is loaded, the controller shifts out 0xFF. When the first bit of that idle byte is clocked, it sets sticky status bit 4 (underrun). An idle byte that is loaded but never clocked before CS_N rises does not set the flag.
- R5: When a byte completes while the receive ring is full, the byte is discarded, the receive head pointer does not move, and sticky status bit 5 (overflow) is set.
- R6: Status bits 4 and 5 stay set until the CPU writes 1 to them at register 0x810. Writing 0 to a bit leaves it unchanged.
- R7: A ring is empty when its two pointers are equal in all 11 bits. It is full when the low 10 bits are equal and bit 10 differs. Status bits 0/1 report receive empty/full, and bits 2/3 report transmit empty/full.
- R8: A CPU write into ring memory takes effect only when it is a word-size (size code 2), word-aligned write to the transmit half. Byte writes (size 0), halfword writes (size 1), and any write to the receive half leave memory unchanged.
- R9: A CPU read of ring memory with size 0 or 1 returns the addressed byte or halfword in the low bits, zero-extended. Size 2 returns the whole word. Read data appears on `cpu_rdata` one clock after the request.
- R10: When CS_N rises in the middle of a byte, the partly received bits are discarded and the bit counter restarts. The next byte after CS_N falls again is received intact.
- R11: `rx_irq` is high exactly when the receive fill level (head minus tail, modulo 2048) is greater than or equal to the threshold register 0x814.
- R12: The pointer registers read back the current pointer values: receive head 0x800, receive tail 0x804, transmit head 0x808, transmit tail 0x80C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the bus controller |
| spi_miso | output | 1 | Serial data to the bus controller |
| cpu_en | input | 1 | CPU access strobe, one cycle per access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | 12 | Byte address: 0x000 receive ring, 0x400 transmit ring, 0x800 registers |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| rx_irq | output | 1 | Receive threshold reached |

## Verification
The bench checks that the trailing load at the end of the last byte, which happens before CS_N rises, consumes nothing. A design that advanced the transmit tail at load time would lose a byte, and would report an underrun that never reached the wire. The bench forces the receive ring full by moving the tail pointer so that only the wrap bit differs from the head. A design that compared only the low 10 bits would take this as empty and overwrite data. The bench also sends byte and halfword writes, and a write to the receive half, and reads the memory back. A design with wrong write gating would corrupt neighbouring lanes. A transfer cut off mid-byte shows whether stale bits leak into the next byte.

// File: rtl/sptf_pkg.sv
package sptf_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } xfer_size_e;

   typedef enum logic [2:0] {
      REG_RX_HEAD = 3'd0,
      REG_RX_TAIL = 3'd1,
      REG_TX_HEAD = 3'd2,
      REG_TX_TAIL = 3'd3,
      REG_STATUS  = 3'd4,
      REG_THRESH  = 3'd5
   } reg_sel_e;

   // field order matches status bit positions 5..0
   typedef struct packed {
      logic overflow;
      logic underrun;
      logic tx_full;
      logic tx_empty;
      logic rx_full;
      logic rx_empty;
   } status_t;

   localparam int unsigned STATUS_W = $bits(status_t);
   localparam int unsigned ST_UNDERRUN = 4;
   localparam int unsigned ST_OVERFLOW = 5;

endpackage

// File: rtl/sptf_ring.sv
module sptf_ring #(
   parameter int unsigned PTR_W = 11
) (
   input  logic [PTR_W-1:0] head,
   input  logic [PTR_W-1:0] tail,
   output logic             empty,
   output logic             full
);
   localparam int unsigned LOW_W = PTR_W - 1;

   logic low_eq;
   assign low_eq = (head[LOW_W-1:0] == tail[LOW_W-1:0]);
   assign empty  = low_eq && (head[LOW_W] == tail[LOW_W]);
   assign full   = low_eq && (head[LOW_W] != tail[LOW_W]);
endmodule

// File: rtl/sptf_ram.sv
module sptf_ram #(
   parameter  int unsigned WORDS = 256,
   parameter  int unsigned NREAD = 1,
   localparam int unsigned IDX_W = $clog2(WORDS)
) (
   input  logic                   clk,
   input  logic                   we,
   input  logic [3:0]             wbe,
   input  logic [IDX_W-1:0]       widx,
   input  logic [31:0]            wdata,
   input  logic [NREAD*IDX_W-1:0] ridx,
   output logic [NREAD*32-1:0]    rdata
);
   genvar g, r;
   generate
      for (g = 0; g < 4; g++) begin : g_lane
         logic [7:0] lane_mem [WORDS];
         always_ff @(posedge clk) begin
            if (we && wbe[g]) lane_mem[widx] <= wdata[8*g +: 8];
         end
         for (r = 0; r < NREAD; r++) begin : g_rd
            assign rdata[32*r + 8*g +: 8] = lane_mem[ridx[IDX_W*r +: IDX_W]];
         end
      end
   endgenerate
endmodule

// File: rtl/sptf_spi_shift.sv
module sptf_spi_shift #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [7:0]  IDLE_BYTE   = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclk_i,
   input  logic       cs_n_i,
   input  logic       mosi_i,
   output logic       miso_o,
   output logic       rx_valid_o,
   output logic [7:0] rx_byte_o,
   output logic       tx_load_o,
   input  logic       tx_have_i,
   input  logic [7:0] tx_byte_i,
   output logic       tx_pop_o,
   output logic       tx_starve_o
);
   localparam logic [2:0] PIN_RST = 3'b010;

   logic [2:0] chain [SYNC_STAGES];
   logic       sclk_s, cs_s, mosi_s;
   logic       sclk_q, cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < SYNC_STAGES; k++) chain[k] <= PIN_RST;
         sclk_q <= 1'b0;
         cs_q   <= 1'b1;
      end else begin
         chain[0] <= {sclk_i, cs_n_i, mosi_i};
         for (int k = 1; k < SYNC_STAGES; k++) chain[k] <= chain[k-1];
         sclk_q <= sclk_s;
         cs_q   <= cs_s;
      end
   end
   assign {sclk_s, cs_s, mosi_s} = chain[SYNC_STAGES-1];

   logic rise, fall, start;
   assign start = cs_q & ~cs_s;
   assign rise  = ~cs_s & sclk_s & ~sclk_q;
   assign fall  = ~cs_s & ~sclk_s & sclk_q;

   logic [2:0] bit_cnt;
   logic [6:0] rx_sh;
   logic [7:0] tx_sh;
   logic       need_load;
   logic       from_ring;

   assign tx_load_o   = start | (fall & need_load);
   assign tx_pop_o    = rise & (bit_cnt == 3'd0) & from_ring;
   assign tx_starve_o = rise & (bit_cnt == 3'd0) & ~from_ring;
   assign miso_o      = tx_sh[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt    <= '0;
         rx_sh      <= '0;
         tx_sh      <= IDLE_BYTE;
         need_load  <= 1'b0;
         from_ring  <= 1'b0;
         rx_valid_o <= 1'b0;
         rx_byte_o  <= '0;
      end else begin
         rx_valid_o <= 1'b0;
         if (cs_s) begin
            bit_cnt   <= '0;
            need_load <= 1'b0;
         end else if (start) begin
            tx_sh     <= tx_have_i ? tx_byte_i : IDLE_BYTE;
            from_ring <= tx_have_i;
            bit_cnt   <= '0;
            need_load <= 1'b0;
         end else if (rise) begin
            rx_sh   <= {rx_sh[5:0], mosi_s};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
               rx_valid_o <= 1'b1;
               rx_byte_o  <= {rx_sh, mosi_s};
               need_load  <= 1'b1;
            end
         end else if (fall) begin
            if (need_load) begin
               tx_sh     <= tx_have_i ? tx_byte_i : IDLE_BYTE;
               from_ring <= tx_have_i;
               need_load <= 1'b0;
            end else begin
               tx_sh <= {tx_sh[6:0], 1'b0};
            end
         end
      end
   end
endmodule

// File: rtl/spi_target_fifo.sv
module spi_target_fifo #(
   parameter  int unsigned FIFO_BYTES   = 1024,
   parameter  int unsigned SYNC_STAGES  = 2,
   parameter  logic [7:0]  IDLE_BYTE    = 8'hFF,
   parameter  int unsigned THRESH_RESET = 1,
   localparam int unsigned AW     = $clog2(FIFO_BYTES),
   localparam int unsigned PTR_W  = AW + 1,
   localparam int unsigned CPU_AW = AW + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   input  logic              cpu_en,
   input  logic              cpu_we,
   input  logic [1:0]        cpu_size,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [31:0]       cpu_wdata,
   output logic [31:0]       cpu_rdata,
   output logic              rx_irq
);
   import sptf_pkg::*;

   localparam int unsigned WORDS  = FIFO_BYTES / 4;
   localparam int unsigned WIDX_W = AW - 2;

   generate
      if ((FIFO_BYTES & (FIFO_BYTES - 1)) != 0 || FIFO_BYTES < 8) begin : g_bad_depth
         $error("FIFO_BYTES must be a power of two of at least 8");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (THRESH_RESET > FIFO_BYTES) begin : g_bad_thresh
         $error("THRESH_RESET exceeds ring size");
      end
   endgenerate

   // pointer state: hardware owns rx_head and tx_tail, CPU owns the others
   logic [PTR_W-1:0] rx_head_q, rx_tail_q, tx_head_q, tx_tail_q, thresh_q;
   logic             unf_q, ovf_q;
   logic             rx_empty, rx_full, tx_empty, tx_full;

   sptf_ring #(.PTR_W(PTR_W)) u_rx_ring (
      .head(rx_head_q), .tail(rx_tail_q), .empty(rx_empty), .full(rx_full));
   sptf_ring #(.PTR_W(PTR_W)) u_tx_ring (
      .head(tx_head_q), .tail(tx_tail_q), .empty(tx_empty), .full(tx_full));

   // serial side
   logic       rx_valid, tx_load, tx_pop, tx_starve;
   logic [7:0] rx_byte, tx_byte;
   logic [31:0] tx_hw_word;

   sptf_spi_shift #(.SYNC_STAGES(SYNC_STAGES), .IDLE_BYTE(IDLE_BYTE)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi), .miso_o(spi_miso),
      .rx_valid_o(rx_valid), .rx_byte_o(rx_byte),
      .tx_load_o(tx_load), .tx_have_i(~tx_empty), .tx_byte_i(tx_byte),
      .tx_pop_o(tx_pop), .tx_starve_o(tx_starve));

   logic tx_load_seen;
   assign tx_load_seen = tx_load;
   assign tx_byte = tx_hw_word[{tx_tail_q[1:0], 3'b000} +: 8];

   // CPU decode
   logic              is_reg, is_tx, wr_strobe, rd_strobe;
   logic [WIDX_W-1:0] cpu_widx;
   logic [1:0]        lane;
   reg_sel_e          reg_sel;

   assign is_reg    = cpu_addr[CPU_AW-1];
   assign is_tx     = cpu_addr[AW];
   assign cpu_widx  = cpu_addr[AW-1:2];
   assign lane      = cpu_addr[1:0];
   assign reg_sel   = reg_sel_e'(cpu_addr[4:2]);
   assign wr_strobe = cpu_en & cpu_we;
   assign rd_strobe = cpu_en & ~cpu_we;

   // receive memory: hardware writes single bytes, CPU reads
   logic        rx_accept;
   logic [31:0] rx_cpu_word;
   assign rx_accept = rx_valid & ~rx_full;

   sptf_ram #(.WORDS(WORDS), .NREAD(1)) u_rx_ram (
      .clk(clk), .we(rx_accept), .wbe(4'b0001 << rx_head_q[1:0]),
      .widx(rx_head_q[AW-1:2]), .wdata({4{rx_byte}}),
      .ridx(cpu_widx), .rdata(rx_cpu_word));

   // transmit memory: CPU writes aligned words, hardware and CPU read
   logic        tx_cpu_we;
   logic [31:0] tx_cpu_word;
   assign tx_cpu_we = wr_strobe & ~is_reg & is_tx
                    & (cpu_size == SZ_WORD) & (lane == 2'b00);

   sptf_ram #(.WORDS(WORDS), .NREAD(2)) u_tx_ram (
      .clk(clk), .we(tx_cpu_we), .wbe(4'b1111),
      .widx(cpu_widx), .wdata(cpu_wdata),
      .ridx({cpu_widx, tx_tail_q[AW-1:2]}),
      .rdata({tx_cpu_word, tx_hw_word}));

   // pointer and flag registers
   logic clr_unf, clr_ovf;
   assign clr_unf = wr_strobe & is_reg & (reg_sel == REG_STATUS) & cpu_wdata[ST_UNDERRUN];
   assign clr_ovf = wr_strobe & is_reg & (reg_sel == REG_STATUS) & cpu_wdata[ST_OVERFLOW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_head_q <= '0;
         rx_tail_q <= '0;
         tx_head_q <= '0;
         tx_tail_q <= '0;
         thresh_q  <= PTR_W'(THRESH_RESET);
         unf_q     <= 1'b0;
         ovf_q     <= 1'b0;
      end else begin
         if (rx_accept) rx_head_q <= rx_head_q + PTR_W'(1);
         if (tx_pop)    tx_tail_q <= tx_tail_q + PTR_W'(1);
         unf_q <= (unf_q & ~clr_unf) | tx_starve;
         ovf_q <= (ovf_q & ~clr_ovf) | (rx_valid & rx_full);
         if (wr_strobe && is_reg) begin
            case (reg_sel)
               REG_RX_TAIL: rx_tail_q <= cpu_wdata[PTR_W-1:0];
               REG_TX_HEAD: tx_head_q <= cpu_wdata[PTR_W-1:0];
               REG_THRESH:  thresh_q  <= cpu_wdata[PTR_W-1:0];
               default: ;
            endcase
         end
      end
   end

   status_t status;
   always_comb begin
      status.overflow = ovf_q;
      status.underrun = unf_q;
      status.tx_full  = tx_full;
      status.tx_empty = tx_empty;
      status.rx_full  = rx_full;
      status.rx_empty = rx_empty;
   end

   // read path
   logic [31:0] mem_word, mem_shift, rd_next;
   always_comb begin
      mem_word  = is_tx ? tx_cpu_word : rx_cpu_word;
      mem_shift = mem_word >> {lane, 3'b000};
      if (is_reg) begin
         case (reg_sel)
            REG_RX_HEAD: rd_next = 32'(rx_head_q);
            REG_RX_TAIL: rd_next = 32'(rx_tail_q);
            REG_TX_HEAD: rd_next = 32'(tx_head_q);
            REG_TX_TAIL: rd_next = 32'(tx_tail_q);
            REG_STATUS:  rd_next = 32'(status);
            REG_THRESH:  rd_next = 32'(thresh_q);
            default:     rd_next = '0;
         endcase
      end else begin
         case (cpu_size)
            SZ_BYTE: rd_next = {24'd0, mem_shift[7:0]};
            SZ_HALF: rd_next = {16'd0, mem_shift[15:0]};
            default: rd_next = mem_shift;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cpu_rdata <= '0;
      else if (rd_strobe) cpu_rdata <= rd_next;
   end

   logic [PTR_W-1:0] rx_level;
   assign rx_level = rx_head_q - rx_tail_q;
   assign rx_irq   = (rx_level >= thresh_q);
endmodule

// File: rtl/sptf_checker.sv
module sptf_checker #(
   parameter int unsigned PTR_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic [PTR_W-1:0] rx_head,
   input logic [PTR_W-1:0] tx_tail,
   input logic [PTR_W-1:0] thresh,
   input logic             rx_full,
   input logic             rx_empty,
   input logic             unf,
   input logic             ovf,
   input logic             cpu_en,
   input logic             cpu_we,
   input logic             irq
);
   AST_RX_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_head) |-> rx_head == PTR_W'($past(rx_head) + PTR_W'(1))); // R2
   AST_TX_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tx_tail) |-> tx_tail == PTR_W'($past(tx_tail) + PTR_W'(1))); // R3
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full |=> $stable(rx_head)); // R5
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !(cpu_en && cpu_we)) |=> ovf); // R6
   AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (unf && !(cpu_en && cpu_we)) |=> unf); // R4
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_empty && thresh != '0) |-> !irq); // R11
endmodule

bind spi_target_fifo sptf_checker #(.PTR_W(PTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .rx_head(rx_head_q), .tx_tail(tx_tail_q), .thresh(thresh_q),
   .rx_full(rx_full), .rx_empty(rx_empty),
   .unf(unf_q), .ovf(ovf_q),
   .cpu_en(cpu_en), .cpu_we(cpu_we), .irq(rx_irq));

// File: tb/tb_spi_target_fifo.sv
module tb_spi_target_fifo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic        miso;
   logic        cpu_en = 1'b0, cpu_we = 1'b0;
   logic [1:0]  cpu_size = 2'd2;
   logic [11:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [11:0] A_RXH = 12'h800, A_RXT = 12'h804, A_TXH = 12'h808,
                           A_TXT = 12'h80C, A_ST = 12'h810, A_TH = 12'h814;

   always #4 clk = ~clk;

   spi_target_fifo dut (
      .clk(clk), .rst_n(rst_n),
      .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
      .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rx_irq(irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic cpu_wr(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d);
      @(negedge clk);
      cpu_en = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_size = sz; cpu_wdata = d;
      @(negedge clk);
      cpu_en = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic cpu_rd(input logic [11:0] a, input logic [1:0] sz, output logic [31:0] d);
      @(negedge clk);
      cpu_en = 1'b1; cpu_we = 1'b0; cpu_addr = a; cpu_size = sz;
      @(negedge clk);
      cpu_en = 1'b0;
      d = cpu_rdata;
   endtask

   task automatic cs_low();
      @(negedge clk); cs_n = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic cs_high();
      repeat (5) @(negedge clk);
      cs_n = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   task automatic spi_bits(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
      mi = '0;
      for (int i = 7; i > 7 - nbits; i--) begin
         @(negedge clk); mosi = mo[i];
         repeat (4) @(negedge clk);
         mi[i] = miso;
         sclk = 1'b1;
         repeat (4) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (4) @(negedge clk);
   endtask

   logic [7:0]  mi;
   logic [31:0] rd;
   int          rx_cnt = 0;

   task automatic t_reset();
      cpu_rd(A_ST, 2'd2, rd);  chk("R1 status", rd, 32'h05);
      chk("R1 irq", {31'd0, irq}, 32'd0);
      cpu_rd(A_RXH, 2'd2, rd); chk("R1 rx head", rd, 0);
      cpu_rd(A_TXT, 2'd2, rd); chk("R1 tx tail", rd, 0);
   endtask

   task automatic t_rx_basic();
      cpu_wr(A_TH, 2'd2, 32'd3);
      cs_low();
      spi_bits(8'hA5, 8, mi); chk("R4 idle byte 0", {24'd0, mi}, 32'hFF);
      spi_bits(8'h3C, 8, mi);
      chk("R11 irq below threshold", {31'd0, irq}, 32'd0);
      spi_bits(8'h81, 8, mi);
      chk("R11 irq at threshold", {31'd0, irq}, 32'd1);
      spi_bits(8'h7E, 8, mi); chk("R4 idle byte 3", {24'd0, mi}, 32'hFF);
      cs_high();
      rx_cnt = 4;
      cpu_rd(12'h000, 2'd2, rd); chk("R2 rx word", rd, 32'h7E813CA5);
      cpu_rd(12'h002, 2'd1, rd); chk("R9 half read", rd, 32'h7E81);
      cpu_rd(12'h001, 2'd0, rd); chk("R9 byte read", rd, 32'h3C);
      cpu_rd(A_RXH, 2'd2, rd);   chk("R12 rx head", rd, 32'd4);
      cpu_wr(A_RXT, 2'd2, 32'd3);
      chk("R11 irq after tail moves", {31'd0, irq}, 32'd0);
      cpu_rd(A_RXT, 2'd2, rd);   chk("R12 rx tail", rd, 32'd3);
      cpu_wr(A_RXT, 2'd2, 32'd4);
      cpu_rd(A_ST, 2'd2, rd);    chk("R7 rx empty bit", rd & 32'h3, 32'h1);
   endtask

   task automatic t_cs_abort();
      cs_low();
      spi_bits(8'hFF, 3, mi);
      cs_high();
      cs_low();
      spi_bits(8'h5A, 8, mi);
      cs_high();
      rx_cnt = 5;
      cpu_rd(A_RXH, 2'd2, rd);   chk("R10 head after abort", rd, 32'd5);
      cpu_rd(12'h004, 2'd0, rd); chk("R10 clean byte", rd, 32'h5A);
   endtask

   task automatic t_sticky();
      cpu_rd(A_ST, 2'd2, rd);   chk("R4 underrun set", (rd >> 4) & 1, 32'd1);
      cpu_wr(A_ST, 2'd2, 32'h0);
      cpu_rd(A_ST, 2'd2, rd);   chk("R6 write 0 keeps", (rd >> 4) & 1, 32'd1);
      cpu_wr(A_ST, 2'd2, 32'h10);
      cpu_rd(A_ST, 2'd2, rd);   chk("R6 write 1 clears", (rd >> 4) & 1, 32'd0);
   endtask

   task automatic t_tx();
      logic [7:0] exp_b [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
      cpu_wr(12'h400, 2'd2, 32'h44332211);
      cpu_wr(A_TXH, 2'd2, 32'd4);
      cs_low();
      for (int k = 0; k < 4; k++) begin
         spi_bits(8'h00, 8, mi);
         chk("R3 tx byte", {24'd0, mi}, {24'd0, exp_b[k]});
      end
      cs_high();
      cpu_rd(A_TXT, 2'd2, rd); chk("R12 tx tail", rd, 32'd4);
      cpu_rd(A_ST, 2'd2, rd);  chk("R4 unclocked idle no flag", (rd >> 4) & 1, 32'd0);
      cs_low();
      spi_bits(8'h00, 8, mi);  chk("R4 idle when empty", {24'd0, mi}, 32'hFF);
      cs_high();
      rx_cnt = 10;
      cpu_rd(A_ST, 2'd2, rd);  chk("R4 underrun flag", (rd >> 4) & 1, 32'd1);
      cpu_rd(A_TXT, 2'd2, rd); chk("R3 tail holds on idle", rd, 32'd4);
   endtask

   task automatic t_sizes();
      cpu_wr(12'h404, 2'd2, 32'h01020304);
      cpu_wr(12'h405, 2'd0, 32'hAAAAAAAA);
      cpu_wr(12'h406, 2'd1, 32'hBBBBBBBB);
      cpu_rd(12'h404, 2'd2, rd); chk("R8 narrow writes ignored", rd, 32'h01020304);
      cpu_wr(12'h000, 2'd2, 32'hFFFFFFFF);
      cpu_rd(12'h000, 2'd2, rd); chk("R8 rx half not writable", rd, 32'h7E813CA5);
   endtask

   task automatic t_overflow();
      cpu_wr(A_RXT, 2'd2, 32'(rx_cnt + 1024));
      cpu_rd(A_ST, 2'd2, rd);  chk("R7 rx full bits", rd & 32'h3, 32'h2);
      cs_low();
      spi_bits(8'h99, 8, mi);
      cs_high();
      cpu_rd(A_RXH, 2'd2, rd); chk("R5 head unchanged", rd, 32'(rx_cnt));
      cpu_rd(A_ST, 2'd2, rd);  chk("R5 overflow flag", (rd >> 5) & 1, 32'd1);
      cpu_wr(A_ST, 2'd2, 32'h20);
      cpu_rd(A_ST, 2'd2, rd);  chk("R6 overflow cleared", (rd >> 5) & 1, 32'd0);
      cpu_wr(A_RXT, 2'd2, 32'(rx_cnt));
      cpu_wr(A_TXH, 2'd2, 32'd1028);
      cpu_rd(A_ST, 2'd2, rd);  chk("R7 tx full bits", (rd >> 2) & 3, 32'h2);
      cpu_wr(A_TXH, 2'd2, 32'd4);
      cpu_rd(A_ST, 2'd2, rd);  chk("R7 tx empty bits", (rd >> 2) & 3, 32'h1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_rx_basic();
      t_cs_abort();
      t_sticky();
      t_tx();
      t_sizes();
      t_overflow();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule